// File: doc/BRIEF.md
# Bit-Slice Light Pulse Sequencer

This block runs on the display-controller side of an LED illumination path. It produces a programmed number of discrete light pulses inside one bit slice. A slice opens with the LED current drive requested and the low-resistance shunt engaged, so the inductor charges into the shunt. After a programmable charge delay the shunt request is released and current is steered into the LED. The driver signals the end of each light pulse by pulling an active-low completion flag. The sequencer then re-engages the shunt at once and holds a programmable off time. After the off time it either releases the next pulse or, once the target count is reached, drops the drive request and flags the slice as finished.

A watchdog guards every pulse. If the completion flag does not arrive within a programmable number of cycles, the slice is abandoned and a sticky error flag is raised. The start strobe, the configuration inputs and all outputs are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A start strobe that arrives while a slice is running is dropped, not queued. All timing inputs are counted in clock cycles.

Top module: `bspc_top`

## Requirements
- R1: While reset is active and afterwards until a start, drive request is 0, shunt request is 1, slice-done is 0 and the error flag is 0.
- R2: A start strobe sampled while idle raises the drive request on the next cycle with the shunt request still 1. The shunt stays 1 for exactly charge_delay+1 cycles before the first release.
- R3: When the completion flag is sampled low while the shunt is released, the shunt request is 1 on the very next cycle.
- R4: Between two pulses, the shunt request stays 1 (drive still 1) for exactly off_time+1 cycles before being released again.
- R5: In a slice without timeout, the number of separate shunt-release windows equals the target count. After the last pulse the off time of off_time+1 cycles elapses and then the drive request falls.
- R6: With a target count of 0, the drive request is high for charge_delay+1 cycles and then falls, and the shunt request is never released.
- R7: If the shunt has been released for pulse_timeout+1 cycles without a completion, the drive request falls and the error flag rises on the same cycle.
- R8: The error flag stays 1 until the next accepted start, and it is 0 from the cycle after that start.
- R9: slice_done is a single-cycle pulse that is high exactly in the first cycle in which the drive request is low after being high.
- R10: A start strobe while a slice is running has no effect on the timing or pulse count of that slice.
- R11: The target count is captured at the accepted start. Changing the input during the slice does not change the number of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_start | input | 1 | One-cycle strobe opening a slice |
| target_count | input | CNT_W | Pulses wanted in the slice |
| charge_delay | input | TIME_W | Charge phase length minus one, in cycles |
| off_time | input | TIME_W | Gap between pulses minus one, in cycles |
| pulse_timeout | input | TIME_W | Allowed release time minus one before abort |
| pulse_done_n | input | 1 | Driver completion flag, active low |
| drv_en | output | 1 | LED current drive request |
| shunt_en | output | 1 | Shunt request (0 releases a pulse) |
| slice_done | output | 1 | One-cycle end-of-slice pulse |
| slice_err | output | 1 | Sticky watchdog abort flag |

## Verification
The bench builds the block with CNT_W=4 and TIME_W=6. This makes the largest target of 15 pulses reachable, so the count compare is exercised at its full width without overflow. Timeouts and delays of tens of cycles then fit in short runs. The bench models the driver with a programmable response latency, including a driver that never answers, which drives the watchdog path. It measures every charge, release and off window cycle by cycle against the programmed values.

// File: rtl/bspc_pkg.sv
package bspc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_PULSE  = 2'd2,
    ST_OFF    = 2'd3
  } bspc_state_e;
endpackage

// File: rtl/bspc_timer.sv
module bspc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bspc_pulse_counter.sv
module bspc_pulse_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         incr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (incr)  count <= count + 1'b1;
  end
endmodule

// File: rtl/bspc_fsm.sv
module bspc_fsm
  import bspc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slice_start,
  input  logic [CNT_W-1:0]  target_count,
  input  logic [TIME_W-1:0] charge_delay,
  input  logic [TIME_W-1:0] off_time,
  input  logic [TIME_W-1:0] pulse_timeout,
  input  logic              pulse_done_n,
  input  logic              tmr_expired,
  input  logic [CNT_W-1:0]  pulse_cnt,
  output logic              tmr_load,
  output logic [TIME_W-1:0] tmr_val,
  output logic              tmr_run,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              drv_en,
  output logic              shunt_en,
  output logic              slice_done,
  output logic              slice_err
);
  bspc_state_e state_q, state_d;
  logic [CNT_W-1:0] tgt_q;
  logic finish, abort, accept;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    finish   = 1'b0;
    abort    = 1'b0;
    accept   = 1'b0;
    case (state_q)
      ST_IDLE: if (slice_start) begin
        state_d  = ST_CHARGE;
        tmr_load = 1'b1;
        tmr_val  = charge_delay;
        cnt_clr  = 1'b1;
        accept   = 1'b1;
      end
      ST_CHARGE: if (tmr_expired) begin
        if (tgt_q == '0) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = pulse_timeout;
        end
      end
      ST_PULSE: if (!pulse_done_n) begin
        state_d  = ST_OFF;
        cnt_inc  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = off_time;
      end else if (tmr_expired) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
        abort   = 1'b1;
      end
      ST_OFF: if (tmr_expired) begin
        if (pulse_cnt == tgt_q) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = pulse_timeout;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_run = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tgt_q      <= '0;
      drv_en     <= 1'b0;
      shunt_en   <= 1'b1;
      slice_done <= 1'b0;
      slice_err  <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (accept) tgt_q <= target_count;
      drv_en     <= (state_d != ST_IDLE);
      shunt_en   <= (state_d != ST_PULSE);
      slice_done <= finish;
      if (accept)     slice_err <= 1'b0;
      else if (abort) slice_err <= 1'b1;
    end
  end

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && slice_start) |=> (drv_en && shunt_en));

  assert_shunt_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE && !pulse_done_n) |=> shunt_en);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (pulse_cnt <= tgt_q));

  assert_zero_no_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && tgt_q == '0) |-> shunt_en);

  assert_err_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slice_err) |-> !drv_en);

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slice_done |-> $fell(drv_en));

  assert_fall_gives_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> slice_done);

  assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && slice_start) |=> $stable(tgt_q));
endmodule

// File: rtl/bspc_top.sv
module bspc_top #(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slice_start,
  input  logic [CNT_W-1:0]  target_count,
  input  logic [TIME_W-1:0] charge_delay,
  input  logic [TIME_W-1:0] off_time,
  input  logic [TIME_W-1:0] pulse_timeout,
  input  logic              pulse_done_n,
  output logic              drv_en,
  output logic              shunt_en,
  output logic              slice_done,
  output logic              slice_err
);
  logic              tmr_load, tmr_run, tmr_expired;
  logic [TIME_W-1:0] tmr_val;
  logic              cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  pulse_cnt;

  bspc_timer #(.W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  bspc_pulse_counter #(.W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clr),
    .incr  (cnt_inc),
    .count (pulse_cnt)
  );

  bspc_fsm #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .slice_start   (slice_start),
    .target_count  (target_count),
    .charge_delay  (charge_delay),
    .off_time      (off_time),
    .pulse_timeout (pulse_timeout),
    .pulse_done_n  (pulse_done_n),
    .tmr_expired   (tmr_expired),
    .pulse_cnt     (pulse_cnt),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .tmr_run       (tmr_run),
    .cnt_clr       (cnt_clr),
    .cnt_inc       (cnt_inc),
    .drv_en        (drv_en),
    .shunt_en      (shunt_en),
    .slice_done    (slice_done),
    .slice_err     (slice_err)
  );
endmodule

// File: tb/bspc_top_tb.sv
module bspc_top_tb;
  localparam int CNT_W  = 4;
  localparam int TIME_W = 6;
  // columns: target, charge_delay, off_time, driver latency, timeout
  localparam int NVEC = 6;
  localparam int VEC [NVEC][5] = '{
    '{1, 0, 0, 1, 40},
    '{3, 2, 1, 1, 40},
    '{5, 4, 3, 2, 40},
    '{15, 1, 0, 3, 40},
    '{2, 7, 5, 6, 40},
    '{4, 0, 2, 1, 40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slice_start = 1'b0;
  logic [CNT_W-1:0]  target_count = '0;
  logic [TIME_W-1:0] charge_delay = '0;
  logic [TIME_W-1:0] off_time = '0;
  logic [TIME_W-1:0] pulse_timeout = '0;
  logic pulse_done_n = 1'b1;
  logic drv_en, shunt_en, slice_done, slice_err;
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  bspc_top #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .slice_start(slice_start),
    .target_count(target_count), .charge_delay(charge_delay),
    .off_time(off_time), .pulse_timeout(pulse_timeout),
    .pulse_done_n(pulse_done_n), .drv_en(drv_en), .shunt_en(shunt_en),
    .slice_done(slice_done), .slice_err(slice_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_slice(input int tgt, input int chg, input int off,
                           input int lat, input int to, input bit poke);
    int pulses = 0, first_hi = 0, low_run = 0, hi_run = 0, cyc = 0;
    bit prev_low = 0;
    bit exp_err = (lat == 0 && tgt > 0);
    int exp_p = exp_err ? 1 : tgt;
    target_count  = CNT_W'(tgt);
    charge_delay  = TIME_W'(chg);
    off_time      = TIME_W'(off);
    pulse_timeout = TIME_W'(to);
    slice_start   = 1'b1;
    @(negedge clk);
    slice_start = 1'b0;
    chk(drv_en && shunt_en, "R2 start", {drv_en, shunt_en}, 3);
    chk(!slice_err, "R8 err cleared", slice_err, 0);
    while (drv_en && cyc < 4000) begin
      if (prev_low) chk(shunt_en, "R3 shunt back", shunt_en, 1);
      if (!shunt_en) begin
        if (low_run == 0) begin
          pulses++;
          if (pulses > 1) chk(hi_run == off + 1, "R4 off gap", hi_run, off + 1);
          else chk(first_hi == chg + 1, "R2 charge len", first_hi, chg + 1);
        end
        low_run++;
        hi_run = 0;
      end else begin
        if (pulses == 0) first_hi++;
        else hi_run++;
        low_run = 0;
      end
      prev_low = (!shunt_en && lat != 0 && low_run == lat);
      pulse_done_n = !prev_low;
      if (poke && cyc == 2) begin
        slice_start  = 1'b1;
        target_count = CNT_W'(tgt + 2);
      end else if (poke && cyc == 3) begin
        slice_start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    pulse_done_n = 1'b1;
    slice_start  = 1'b0;
    if (poke) chk(pulses == exp_p, "R10 R11 busy start/target change", pulses, exp_p);
    else      chk(pulses == exp_p, "R5 pulse count", pulses, exp_p);
    if (exp_err) begin
      chk(low_run == to + 1, "R7 watchdog window", low_run, to + 1);
    end else if (tgt > 0) begin
      chk(hi_run == off + 1, "R5 final off", hi_run, off + 1);
    end else begin
      chk(first_hi == chg + 1, "R6 zero-target drive len", first_hi, chg + 1);
      chk(pulses == 0, "R6 no release", pulses, 0);
    end
    chk(slice_err == exp_err, "R7 error flag", slice_err, exp_err);
    chk(slice_done && !drv_en && shunt_en, "R9 done at drive fall",
        {slice_done, drv_en, shunt_en}, 5);
    @(negedge clk);
    chk(!slice_done, "R9 done single cycle", slice_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!drv_en && shunt_en && !slice_done && !slice_err, "R1 reset state",
        {drv_en, shunt_en, slice_done, slice_err}, 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!drv_en && shunt_en && !slice_done && !slice_err, "R1 idle after reset",
        {drv_en, shunt_en, slice_done, slice_err}, 4);

    for (int i = 0; i < NVEC; i++) begin
      run_slice(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R6: zero target
    run_slice(0, 3, 2, 1, 40, 1'b0);
    run_slice(0, 0, 0, 1, 40, 1'b0);
    // R7/R8: driver never answers
    run_slice(3, 2, 1, 0, 5, 1'b0);
    repeat (5) @(negedge clk);
    chk(slice_err && !drv_en, "R8 error held while idle", slice_err, 1);
    // R8 clear on next start, plus R10/R11 mid-slice start and target change
    run_slice(3, 6, 2, 2, 40, 1'b1);
    run_slice(13, 1, 1, 1, 40, 1'b1);
    // edge: watchdog just met (latency = timeout + 1)
    run_slice(2, 1, 1, 6, 5, 1'b0);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule